// File: doc/BRIEF.md
# Masked-Write GPIO with Shared Interrupt

A sixteen-pin general-purpose I/O block on a simple word-addressed register bus. Each pin has a direction bit and an output level. Software changes output levels through one write that carries its own per-bit mask, so it can set or clear any subset of pins without first reading the register. A readback register returns the pin levels after a two-flop synchroniser. The upper eight pins can each be enabled into a single shared, active-high interrupt request.

A control register holds a clock enable and a block soft reset. After power-on the block sits in its low-power state, held in reset with the clock stopped. Software brings it up by writing 3 (reset on, clock on) and then 1 (reset off, clock on). Reads are combinational: `rdata_o` is valid in the same cycle as a read request.

Top module: `mwg_top`

## Requirements
- R1: After `rst_ni` is released, the control register reads 2, the direction, output and interrupt-enable registers read 0, `pin_o`, `pin_oe_o` and `irq_o` are 0.
- R2: The control register at offset 0x14 holds the clock enable in bit 0 and the soft reset in bit 1. It accepts writes in every state and reads back its two bits.
- R3: A write to offset 0x08 updates the output register. Bits 31:16 are per-pin write enables and bits 15:0 are the new levels. Only pins whose enable bit is 1 change. Offset 0x08 reads as 0. `pin_o` shows the output register.
- R4: The direction register at offset 0x00 reads back as written. A 1 in a bit makes that pin an output, and `pin_oe_o` shows the register.
- R5: Offset 0x0C returns `pin_i` through two flops. A level applied before clock edge k appears after edge k+1. Writes to 0x0C have no effect.
- R6: The interrupt-enable register at offset 0x10 stores and reads back 16 bits. `irq_o` is the OR over pins 8 to 15 of the synchronised level ANDed with that pin's enable bit. Enable bits 0 to 7 have no effect on `irq_o`.
- R7: While control bit 1 is 1, the direction, output and interrupt-enable registers are cleared from the following edge on, and writes to them are ignored.
- R8: While control is 0 (clock off, reset off), writes to direction, output and interrupt enable are ignored, the synchroniser is frozen and `irq_o` is 0. When the clock is enabled again, the previous state resumes.
- R9: Writing 3 and then 1 to the control register gives a working block with cleared registers, which then accepts writes.
- R10: Reads at unmapped offsets return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle as the read request |
| pin_i | input | 16 | Pin input levels |
| pin_o | output | 16 | Pin output levels |
| pin_oe_o | output | 16 | Pin output enables |
| irq_o | output | 1 | Shared interrupt request from pins 8 to 15 |

## Verification
The hardest case to reach is a resume from the clock-gated state. The synchroniser has to hold a stale level while the pins change. The interrupt must be masked while gated, and then come back from that stale level before the new one arrives. The stimulus enables a pin-8 interrupt and raises pin 8, stops the clock, and drops the pin. It then re-enables the clock and checks `irq_o` and the readback edge by edge. Similar ordered sequences check that writes are ignored in soft reset and while gated, and the latency from pin to readback.

// File: rtl/mwg_pkg.sv
package mwg_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_DIR = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_OUT = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_PIN = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_IE  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CTL = 5'h14;

  // bit 1 soft reset, bit 0 clock enable
  typedef struct packed {
    logic soft_rst;
    logic clk_en;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{soft_rst: 1'b1, clk_en: 1'b0};
endpackage

// File: rtl/mwg_sync.sv
module mwg_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (en_i) begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

  AST_SYNC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o)); // R8
endmodule

// File: rtl/mwg_irq.sv
module mwg_irq #(
  parameter int unsigned N_PINS    = 16,
  parameter int unsigned SHARED_LO = 8
) (
  input  logic [N_PINS-1:0] level_i,
  input  logic [N_PINS-1:0] ie_i,
  input  logic              active_i,
  output logic              irq_o
);
  localparam int unsigned N_SHARED = N_PINS - SHARED_LO;

  logic [N_SHARED-1:0] hit;

  for (genvar g = 0; g < N_SHARED; g++) begin : g_shared
    assign hit[g] = level_i[SHARED_LO+g] & ie_i[SHARED_LO+g];
  end

  assign irq_o = active_i & (|hit);
endmodule

// File: rtl/mwg_regs.sv
module mwg_regs
  import mwg_pkg::*;
#(
  parameter int unsigned N_PINS = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_state_i,
  output logic [N_PINS-1:0] dir_o,
  output logic [N_PINS-1:0] out_o,
  output logic [N_PINS-1:0] ie_o,
  output ctl_t              ctl_o
);
  localparam int unsigned HALF = DATA_W / 2;

  ctl_t              ctl_q;
  logic [N_PINS-1:0] dir_q, out_q, ie_q;
  logic              wr_hit, rd_hit;
  logic [N_PINS-1:0] wmask, wval;

  assign wr_hit = req_i & we_i;
  assign rd_hit = req_i & ~we_i;
  assign wmask  = wdata_i[HALF +: N_PINS];
  assign wval   = wdata_i[N_PINS-1:0];

  // control register accepts writes in every state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= CTL_RESET;
    else if (wr_hit && addr_i == OFS_CTL) ctl_q <= ctl_t'(wdata_i[1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
      ie_q  <= '0;
    end else if (ctl_q.soft_rst) begin
      dir_q <= '0;
      out_q <= '0;
      ie_q  <= '0;
    end else if (ctl_q.clk_en && wr_hit) begin
      if (addr_i == OFS_DIR) dir_q <= wval;
      if (addr_i == OFS_OUT) out_q <= (out_q & ~wmask) | (wval & wmask);
      if (addr_i == OFS_IE)  ie_q  <= wval;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_hit) begin
      case (addr_i)
        OFS_DIR: rdata_o[N_PINS-1:0] = dir_q;
        OFS_PIN: rdata_o[N_PINS-1:0] = pin_state_i;
        OFS_IE:  rdata_o[N_PINS-1:0] = ie_q;
        OFS_CTL: rdata_o[1:0]        = ctl_q;
        default: rdata_o             = '0;
      endcase
    end
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
  assign ie_o  = ie_q;
  assign ctl_o = ctl_q;

  AST_SOFT_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.soft_rst |=> (dir_q == '0 && out_q == '0 && ie_q == '0)); // R7
  AST_GATED_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q.clk_en && !ctl_q.soft_rst) |=> ($stable(dir_q) && $stable(out_q) && $stable(ie_q))); // R8
  AST_MASK_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && addr_i == OFS_OUT && ctl_q.clk_en && !ctl_q.soft_rst)
    |=> (((out_q ^ $past(out_q)) & ~$past(wmask)) == '0)); // R3
  AST_MASK_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && addr_i == OFS_OUT && ctl_q.clk_en && !ctl_q.soft_rst)
    |=> (((out_q ^ $past(wval)) & $past(wmask)) == '0)); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && addr_i != OFS_DIR && addr_i != OFS_PIN && addr_i != OFS_IE && addr_i != OFS_CTL)
    |-> rdata_o == '0); // R10
endmodule

// File: rtl/mwg_top.sv
module mwg_top
  import mwg_pkg::*;
#(
  parameter int unsigned N_PINS    = 16,
  parameter int unsigned SHARED_LO = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [4:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic              irq_o
);
  ctl_t              ctl;
  logic [N_PINS-1:0] level, ie;
  logic              active;

  mwg_regs #(.N_PINS(N_PINS), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .pin_state_i (level),
    .dir_o       (pin_oe_o),
    .out_o       (pin_o),
    .ie_o        (ie),
    .ctl_o       (ctl)
  );

  mwg_sync #(.WIDTH(N_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctl.clk_en),
    .d_i    (pin_i),
    .q_o    (level)
  );

  assign active = ctl.clk_en & ~ctl.soft_rst;

  mwg_irq #(.N_PINS(N_PINS), .SHARED_LO(SHARED_LO)) u_irq (
    .level_i  (level),
    .ie_i     (ie),
    .active_i (active),
    .irq_o    (irq_o)
  );

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl.clk_en |-> !irq_o); // R8
  AST_IRQ_UPPER_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ie[N_PINS-1:SHARED_LO] != '0)); // R6
endmodule

// File: tb/mwg_top_tb.sv
`timescale 1ns/1ps
module mwg_top_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [15:0] pins = '0, pout, poe;
  logic        irq;

  int n_total = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    int          kind; // 0 rdata, 1 irq, 2 pin_o, 3 pin_oe_o
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  mwg_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pout),
    .pin_oe_o(poe), .irq_o(irq)
  );

  task automatic idle();
    @(negedge clk);
    req = 0; we = 0; addr = '0; wdata = '0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
  endtask

  task automatic exp_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    req = 1; we = 0; addr = a; wdata = '0;
    sb.push_back('{kind: 0, exp: e, tag: tag});
  endtask

  task automatic exp_port(input int k, input logic [31:0] e, input string tag);
    @(negedge clk);
    req = 0; we = 0; addr = '0; wdata = '0;
    sb.push_back('{kind: k, exp: e, tag: tag});
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk);
    req = 0; we = 0; pins = v;
  endtask

  // monitor: compare queued expectations mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = sb.pop_front();
        case (it.kind)
          0: got = rdata;
          1: got = {31'd0, irq};
          2: got = {16'd0, pout};
          default: got = {16'd0, poe};
        endcase
        n_total++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s: kind %0d got %h exp %h", it.tag, it.kind, got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    exp_rd(5'h14, 32'h2, "R1");
    exp_rd(5'h00, 32'h0, "R1");
    exp_rd(5'h10, 32'h0, "R1");
    exp_port(2, 32'h0, "R1");
    exp_port(3, 32'h0, "R1");
    exp_port(1, 32'h0, "R1");
    // R7 writes ignored while held in reset
    wr(5'h00, 32'hffff);
    exp_rd(5'h00, 32'h0, "R7");
    // R9 bring-up
    wr(5'h14, 32'h3);
    wr(5'h14, 32'h1);
    exp_rd(5'h14, 32'h1, "R2");
    exp_rd(5'h00, 32'h0, "R9");
    // R4 direction
    wr(5'h00, 32'h00f0);
    exp_rd(5'h00, 32'h00f0, "R4");
    exp_port(3, 32'h00f0, "R4");
    // R3 masked output
    wr(5'h08, 32'hffff_a5a5);
    exp_port(2, 32'ha5a5, "R3");
    wr(5'h08, 32'h00f0_0000);
    exp_port(2, 32'ha505, "R3");
    wr(5'h08, 32'h0000_ffff);
    exp_port(2, 32'ha505, "R3");
    wr(5'h08, 32'h8002_0000);
    exp_port(2, 32'h2505, "R3");
    exp_rd(5'h08, 32'h0, "R3");
    // R5 synchroniser latency
    set_pins(16'h1234);
    exp_rd(5'h0C, 32'h0, "R5");
    exp_rd(5'h0C, 32'h1234, "R5");
    wr(5'h0C, 32'hffff_ffff);
    exp_rd(5'h0C, 32'h1234, "R5");
    // R6 shared interrupt
    wr(5'h10, 32'h00ff);
    exp_port(1, 32'h0, "R6");
    exp_rd(5'h10, 32'h00ff, "R6");
    wr(5'h10, 32'h0200);
    exp_port(1, 32'h1, "R6");
    wr(5'h10, 32'h0100);
    exp_port(1, 32'h0, "R6");
    set_pins(16'h0100);
    exp_port(1, 32'h0, "R6");
    exp_port(1, 32'h1, "R6");
    // R8 clock gated
    wr(5'h14, 32'h0);
    exp_port(1, 32'h0, "R8");
    wr(5'h00, 32'hffff);
    exp_rd(5'h00, 32'h00f0, "R8");
    wr(5'h08, 32'hffff_ffff);
    exp_port(2, 32'h2505, "R8");
    set_pins(16'h0000);
    idle(); idle();
    exp_rd(5'h0C, 32'h0100, "R8");
    wr(5'h14, 32'h1);
    exp_port(1, 32'h1, "R8");
    idle();
    exp_rd(5'h0C, 32'h0, "R8");
    exp_port(1, 32'h0, "R8");
    // R7 soft reset clears and ignores writes
    wr(5'h14, 32'h3);
    idle();
    exp_rd(5'h00, 32'h0, "R7");
    exp_port(2, 32'h0, "R7");
    exp_rd(5'h10, 32'h0, "R7");
    wr(5'h00, 32'hffff);
    exp_rd(5'h00, 32'h0, "R7");
    exp_rd(5'h14, 32'h3, "R2");
    wr(5'h14, 32'h1);
    wr(5'h00, 32'h0003);
    exp_rd(5'h00, 32'h0003, "R9");
    // R10 unmapped
    wr(5'h04, 32'hffff_ffff);
    exp_rd(5'h04, 32'h0, "R10");
    exp_rd(5'h18, 32'h0, "R10");
    exp_rd(5'h00, 32'h0003, "R10");
    idle(); idle();
    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule